// File: doc/BRIEF.md
# Configurable Eight-Cell Logic Block

This block models the logic portion of one programmable logic tile: eight cells, each built from a 4-input lookup table, a carry unit and an optional output flip-flop. A static configuration word of 20 bits per cell sets the table contents and the cell options. Three tile-wide bits select the clock edge and the source of the carry entering the chain. Every cell receives four data inputs, each with a "connected" flag. The cells share one clock, one clock enable and one set/reset input, and each shared control also has a "connected" flag.

The carry ripples from cell 0 up to cell 7 and leaves the tile as the carry to the tile above. Per-cell options let input 3 take the carry arriving at the cell. They also let input 2 take the combinational table output of the cell below (cascade). Together these options support ripple adders and wide functions. Each cell output is either the table result or the flip-flop holding it. Each cell has its own set/reset polarity and its own synchronous or asynchronous mode.

Top module: `lb_tile`

## Requirements
- R1: A cell's table output for input index k = {in3,in2,in1,in0} is configuration bit P(k), with P(0..15) = 4, 14, 15, 5, 6, 16, 17, 7, 3, 13, 12, 2, 1, 11, 10, 0.
- R2: With cell configuration bit 8 set, the cell's carry-out is the majority of its effective in1, its effective in2 and its incoming carry. Cell 7's carry-out is `carry_up`.
- R3: The carry entering cell 0 is 1 when `cin_force` is 1. Otherwise it equals `carry_below` when `cin_from_below` is 1, and 0 when `cin_from_below` is 0.
- R4: With cell configuration bit 8 clear, the cell passes its incoming carry unchanged to its carry-out.
- R5: With cell configuration bit 9 clear, the cell output is the combinational table result. With it set, the output is a flip-flop that loads the table result on an active clock edge while the clock enable is 1.
- R6: `neg_clk` = 1 makes every flip-flop act on the falling edge of `clk`, and 0 makes it act on the rising edge.
- R7: Cell configuration bit 18 gives the value that set/reset forces (1 = set, 0 = clear). With bit 19 clear, set/reset acts only on an active clock edge with the clock enable at 1, and it has priority over data.
- R8: With cell configuration bit 19 set, an active set/reset forces the flip-flop at once, whatever the clock and clock enable are doing.
- R9: When the clock enable is 0, a flip-flop holds its value across active edges unless an asynchronous set/reset acts on it.
- R10: `carry_to_in3[i]` = 1 makes cell i's in3 the carry arriving at that cell instead of its data input.
- R11: `cascade_to_in2[i]` = 1 for i > 0 makes cell i's in2 the combinational table output of cell i-1. The option has no effect on cell 0.
- R12: A data input or set/reset whose connected flag is 0 reads as 0, and a clock enable whose connected flag is 0 reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| neg_clk | input | 1 | 1 = flip-flops act on the falling edge |
| cin_force | input | 1 | Forces the carry into cell 0 high |
| cin_from_below | input | 1 | Selects `carry_below` as the carry into cell 0 |
| carry_below | input | 1 | Carry-out of the tile below |
| cfg_cells | input | NCELL*20 | Per-cell configuration, cell i at bits [i*20 +: 20] |
| carry_to_in3 | input | NCELL | Per-cell: in3 takes the incoming carry |
| cascade_to_in2 | input | NCELL | Per-cell: in2 takes the previous cell's table output |
| din | input | NCELL*4 | Data inputs, cell i input j at bit i*4+j |
| din_conn | input | NCELL*4 | Connected flags for `din` |
| ce | input | 1 | Shared clock enable |
| ce_conn | input | 1 | Connected flag for `ce` |
| sr | input | 1 | Shared set/reset |
| sr_conn | input | 1 | Connected flag for `sr` |
| cell_out | output | NCELL | Cell outputs |
| carry_up | output | 1 | Carry-out of cell NCELL-1 |

## Verification
The bench builds the block with its default of NCELL = 8. This gives a full 8-bit ripple add, including carries that run the whole chain. It also gives two cells for each of the four set/reset polarity and mode combinations, so set and clear, and synchronous and asynchronous action, can be observed side by side in one output word. An 8-deep cascade shows the previous-output path carrying a running parity across all cells. The 8-cell width also lets each table-index check drive eight different input patterns at the same time.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam int LC_W         = 20;
    localparam int LUT_IN       = 4;
    localparam int CARRY_EN_BIT = 8;
    localparam int FF_EN_BIT    = 9;
    localparam int SET_VAL_BIT  = 18;
    localparam int ASYNC_BIT    = 19;

    // Position of the configuration bit read for table index {in3,in2,in1,in0}
    function automatic logic [4:0] lut_pos(input logic [LUT_IN-1:0] idx);
        logic [4:0] p;
        unique case (idx)
            4'd0:  p = 5'd4;
            4'd1:  p = 5'd14;
            4'd2:  p = 5'd15;
            4'd3:  p = 5'd5;
            4'd4:  p = 5'd6;
            4'd5:  p = 5'd16;
            4'd6:  p = 5'd17;
            4'd7:  p = 5'd7;
            4'd8:  p = 5'd3;
            4'd9:  p = 5'd13;
            4'd10: p = 5'd12;
            4'd11: p = 5'd2;
            4'd12: p = 5'd1;
            4'd13: p = 5'd11;
            4'd14: p = 5'd10;
            default: p = 5'd0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/lb_lut.sv
module lb_lut
    import lb_pkg::*;
(
    input  logic [LC_W-1:0]   cfg_i,
    input  logic [LUT_IN-1:0] sel_i,
    output logic              lout_o
);
    assign lout_o = cfg_i[lut_pos(sel_i)];

    // R1: the two ends of the index range read the fixed corner bits
    always_comb begin
        if (sel_i == '0) begin
            p_lut_low_r1: assert (lout_o == cfg_i[4]);
        end
        if (sel_i == '1) begin
            p_lut_high_r1: assert (lout_o == cfg_i[0]);
        end
    end
endmodule

// File: rtl/lb_ff.sv
module lb_ff (
    input  logic clk_i,
    input  logic ce_i,
    input  logic sr_i,
    input  logic async_i,
    input  logic setval_i,
    input  logic d_i,
    output logic q_o
);
    logic arst;
    assign arst = sr_i & async_i;

    always_ff @(posedge clk_i or posedge arst) begin
        if (arst) begin
            q_o <= setval_i;
        end else if (ce_i) begin
            q_o <= sr_i ? setval_i : d_i;
        end
    end

    // R7: synchronous set/reset on an enabled edge loads the chosen value
    p_sync_sr_r7: assert property (@(posedge clk_i) disable iff (arst)
        (sr_i && ce_i) |=> (q_o == $past(setval_i)));

    // R9: a disabled edge leaves the flip-flop unchanged
    p_ce_hold_r9: assert property (@(posedge clk_i) disable iff (arst)
        (!ce_i) |=> $stable(q_o));
endmodule

// File: rtl/lb_cell.sv
module lb_cell
    import lb_pkg::*;
#(
    parameter bit HAS_PREV = 1'b1
) (
    input  logic              clk_i,
    input  logic              ce_i,
    input  logic              sr_i,
    input  logic [LC_W-1:0]   cfg_i,
    input  logic [LUT_IN-1:0] din_i,
    input  logic [LUT_IN-1:0] conn_i,
    input  logic              c_in_i,
    input  logic              casc_i,
    input  logic              use_c3_i,
    input  logic              use_casc_i,
    output logic              lout_o,
    output logic              c_out_o,
    output logic              out_o
);
    logic [LUT_IN-1:0] sel;
    logic              q;

    always_comb begin
        sel = din_i & conn_i;
        if (use_c3_i) begin
            sel[3] = c_in_i;
        end
        if (HAS_PREV && use_casc_i) begin
            sel[2] = casc_i;
        end
    end

    lb_lut u_lut (
        .cfg_i  (cfg_i),
        .sel_i  (sel),
        .lout_o (lout_o)
    );

    assign c_out_o = cfg_i[CARRY_EN_BIT]
                   ? ((sel[1] & sel[2]) | (sel[1] & c_in_i) | (sel[2] & c_in_i))
                   : c_in_i;

    lb_ff u_ff (
        .clk_i    (clk_i),
        .ce_i     (ce_i),
        .sr_i     (sr_i),
        .async_i  (cfg_i[ASYNC_BIT]),
        .setval_i (cfg_i[SET_VAL_BIT]),
        .d_i      (lout_o),
        .q_o      (q)
    );

    assign out_o = cfg_i[FF_EN_BIT] ? q : lout_o;

    // R2: with carry enabled, two ones generate and two zeros kill
    always_comb begin
        if (cfg_i[CARRY_EN_BIT] && sel[1] && sel[2]) begin
            p_carry_gen_r2: assert (c_out_o == 1'b1);
        end
        if (cfg_i[CARRY_EN_BIT] && !sel[1] && !sel[2]) begin
            p_carry_kill_r2: assert (c_out_o == 1'b0);
        end
    end
endmodule

// File: rtl/lb_carry_src.sv
module lb_carry_src (
    input  logic force_i,
    input  logic from_below_i,
    input  logic below_i,
    output logic cin_o
);
    assign cin_o = force_i | (from_below_i & below_i);
endmodule

// File: rtl/lb_tile.sv
module lb_tile
    import lb_pkg::*;
#(
    parameter int NCELL = 8
) (
    input  logic                    clk,
    input  logic                    neg_clk,
    input  logic                    cin_force,
    input  logic                    cin_from_below,
    input  logic                    carry_below,
    input  logic [NCELL*LC_W-1:0]   cfg_cells,
    input  logic [NCELL-1:0]        carry_to_in3,
    input  logic [NCELL-1:0]        cascade_to_in2,
    input  logic [NCELL*LUT_IN-1:0] din,
    input  logic [NCELL*LUT_IN-1:0] din_conn,
    input  logic                    ce,
    input  logic                    ce_conn,
    input  logic                    sr,
    input  logic                    sr_conn,
    output logic [NCELL-1:0]        cell_out,
    output logic                    carry_up
);
    logic             clk_eff;
    logic             ce_eff;
    logic             sr_eff;
    logic             cin_w;
    logic [NCELL-1:0] carry_en;

    assign clk_eff = clk ^ neg_clk;
    assign ce_eff  = ce | ~ce_conn;
    assign sr_eff  = sr & sr_conn;

    lb_carry_src u_cin (
        .force_i      (cin_force),
        .from_below_i (cin_from_below),
        .below_i      (carry_below),
        .cin_o        (cin_w)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        logic c_in_w;
        logic casc_w;
        logic lout_w;
        logic c_out_w;

        if (i == 0) begin : g_first
            assign c_in_w = cin_w;
            assign casc_w = 1'b0;
        end else begin : g_next
            assign c_in_w = g_cell[i-1].c_out_w;
            assign casc_w = g_cell[i-1].lout_w;
        end

        lb_cell #(.HAS_PREV(i > 0)) u_cell (
            .clk_i      (clk_eff),
            .ce_i       (ce_eff),
            .sr_i       (sr_eff),
            .cfg_i      (cfg_cells[i*LC_W +: LC_W]),
            .din_i      (din[i*LUT_IN +: LUT_IN]),
            .conn_i     (din_conn[i*LUT_IN +: LUT_IN]),
            .c_in_i     (c_in_w),
            .casc_i     (casc_w),
            .use_c3_i   (carry_to_in3[i]),
            .use_casc_i (cascade_to_in2[i]),
            .lout_o     (lout_w),
            .c_out_o    (c_out_w),
            .out_o      (cell_out[i])
        );

        assign carry_en[i] = cfg_cells[i*LC_W + CARRY_EN_BIT];
    end

    assign carry_up = g_cell[NCELL-1].c_out_w;

    // R3 / R4: a chain with every carry unit off carries the selected input to the top
    always_comb begin
        if (carry_en == '0 && cin_force) begin
            p_force_top_r3: assert (carry_up == 1'b1);
        end
        if (carry_en == '0) begin
            p_chain_pass_r4: assert (carry_up == (cin_force | (cin_from_below & carry_below)));
        end
    end
endmodule

// File: tb/tb_lb_tile.sv
`timescale 1ns/100ps
module tb_lb_tile;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            neg_clk = 1'b0;
    logic            cin_force = 1'b0;
    logic            cin_from_below = 1'b0;
    logic            carry_below = 1'b0;
    logic [N*20-1:0] cfg_cells = '0;
    logic [N-1:0]    carry_to_in3 = '0;
    logic [N-1:0]    cascade_to_in2 = '0;
    logic [N*4-1:0]  din = '0;
    logic [N*4-1:0]  din_conn = '0;
    logic            ce = 1'b1;
    logic            ce_conn = 1'b1;
    logic            sr = 1'b0;
    logic            sr_conn = 1'b1;
    logic [N-1:0]    cell_out;
    logic            carry_up;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    string   q_tag[$];
    bit [7:0] q_exp[$];
    bit      q_ck[$];
    bit      q_cu[$];

    always #2 clk = ~clk;

    lb_tile #(.NCELL(N)) dut (
        .clk(clk), .neg_clk(neg_clk), .cin_force(cin_force),
        .cin_from_below(cin_from_below), .carry_below(carry_below),
        .cfg_cells(cfg_cells), .carry_to_in3(carry_to_in3),
        .cascade_to_in2(cascade_to_in2), .din(din), .din_conn(din_conn),
        .ce(ce), .ce_conn(ce_conn), .sr(sr), .sr_conn(sr_conn),
        .cell_out(cell_out), .carry_up(carry_up)
    );

    // Table index -> configuration bit, per R1
    function automatic int pos(input int k);
        case (k)
            0: return 4;   1: return 14;  2: return 15;  3: return 5;
            4: return 6;   5: return 16;  6: return 17;  7: return 7;
            8: return 3;   9: return 13;  10: return 12; 11: return 2;
            12: return 1;  13: return 11; 14: return 10; default: return 0;
        endcase
    endfunction

    function automatic logic [19:0] mk(input logic [15:0] t, input bit cen,
                                       input bit ffen, input bit sv, input bit as);
        logic [19:0] c;
        c = '0;
        for (int k = 0; k < 16; k++) c[pos(k)] = t[k];
        c[8] = cen; c[9] = ffen; c[18] = sv; c[19] = as;
        return c;
    endfunction

    task automatic cfg_all(input logic [15:0] t, input bit cen, input bit ffen);
        for (int i = 0; i < N; i++)
            cfg_cells[i*20 +: 20] = mk(t, cen, ffen, (i % 2) == 1, ((i / 2) % 2) == 1);
    endtask

    task automatic din_ab(input logic [7:0] a, input logic [7:0] b);
        for (int i = 0; i < N; i++) begin
            din[i*4 +: 4] = {1'b0, b[i], a[i], 1'b0};
        end
    endtask

    task automatic din_in0(input logic [7:0] d);
        for (int i = 0; i < N; i++) din[i*4 +: 4] = {3'b000, d[i]};
    endtask

    // Driver side of the scoreboard
    task automatic expect_out(input string tag, input logic [7:0] e,
                              input bit ck, input bit ecu);
        q_tag.push_back(tag); q_exp.push_back(e);
        q_ck.push_back(ck);   q_cu.push_back(ecu);
        #0.2;
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            string t; bit [7:0] e; bit ck; bit ecu;
            wait (q_tag.size() != 0);
            t = q_tag.pop_front(); e = q_exp.pop_front();
            ck = q_ck.pop_front(); ecu = q_cu.pop_front();
            checks++;
            if (cell_out !== e || (ck && carry_up !== ecu)) begin
                fails++;
                $display("FAIL %s out=%h exp=%h carry_up=%b exp_carry=%b",
                         t, cell_out, e, carry_up, ecu);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ea, eb, x, e8;
        logic [8:0] s;
        logic [7:0] va [7];
        logic [7:0] vb [7];
        logic       vc [7];
        va = '{8'h00, 8'h01, 8'hFF, 8'hFF, 8'h5A, 8'h80, 8'h3C};
        vb = '{8'h00, 8'h01, 8'h01, 8'hFF, 8'hA5, 8'h80, 8'h0F};
        vc = '{1'b0,  1'b0,  1'b0,  1'b1,  1'b1,  1'b0,  1'b0};

        // Idle state: empty configuration, nothing connected
        #1;
        expect_out("R12 idle zero", 8'h00, 1'b1, 1'b0);

        // R1: single-minterm tables, every index walked
        din_conn = '1;
        for (int k = 0; k < 16; k++) begin
            cfg_all(16'(1 << k), 1'b0, 1'b0);
            for (int p = 0; p < 16; p++) begin
                for (int i = 0; i < N; i++) din[i*4 +: 4] = 4'((p + i) % 16);
                #1;
                e8 = '0;
                for (int i = 0; i < N; i++) e8[i] = (((p + i) % 16) == k);
                expect_out("R1 minterm walk", e8, 1'b0, 1'b0);
            end
        end

        // R1: AND4 in cells 0..3, XOR4 in cells 4..7
        for (int i = 0; i < N; i++)
            cfg_cells[i*20 +: 20] = mk(i < 4 ? 16'h8000 : 16'h6996, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < N; i++) din[i*4 +: 4] = 4'((p + 3 * i) % 16);
            #1;
            e8 = '0;
            for (int i = 0; i < N; i++) begin
                logic [3:0] v;
                v = 4'((p + 3 * i) % 16);
                e8[i] = (i < 4) ? (&v) : (^v);
            end
            expect_out("R1 and/xor", e8, 1'b0, 1'b0);
        end

        // R2 / R10: ripple add, sum table on in3^in2^in1, in3 from carry
        cfg_all(16'hC33C, 1'b1, 1'b0);
        carry_to_in3 = '1;
        cin_from_below = 1'b1;
        for (int v = 0; v < 7; v++) begin
            din_ab(va[v], vb[v]);
            carry_below = vc[v];
            #1;
            s = {1'b0, va[v]} + {1'b0, vb[v]} + {8'h00, vc[v]};
            expect_out("R2 R10 ripple add", s[7:0], 1'b1, s[8]);
        end

        // R3: carry-in selection
        cin_from_below = 1'b0; carry_below = 1'b1; din_ab(8'h0F, 8'h01); #1;
        expect_out("R3 below ignored when unselected", 8'h10, 1'b1, 1'b0);
        cin_force = 1'b1; cin_from_below = 1'b1; carry_below = 1'b0; #1;
        expect_out("R3 force high", 8'h11, 1'b1, 1'b0);
        cin_from_below = 1'b0; din_ab(8'hFF, 8'h00); #1;
        expect_out("R3 force carries through", 8'h00, 1'b1, 1'b1);

        // R4: carry units off, table passes in3 (the carry)
        cin_force = 1'b0; cin_from_below = 1'b1;
        cfg_all(16'hFF00, 1'b0, 1'b0);
        din_ab(8'hFF, 8'hFF);
        carry_below = 1'b1; #1;
        expect_out("R4 pass-through high", 8'hFF, 1'b1, 1'b1);
        carry_below = 1'b0; #1;
        expect_out("R4 no generate when disabled", 8'h00, 1'b1, 1'b0);
        carry_to_in3 = '0; cin_from_below = 1'b0;

        // R11: cascade parity, cell 0 uses in2&in0 and ignores its cascade bit
        cfg_cells[0 +: 20] = mk(16'hA0A0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i < N; i++) cfg_cells[i*20 +: 20] = mk(16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0);
        cascade_to_in2 = '1;
        foreach (va[v]) begin
            x = va[v] ^ {vb[v][3:0], vb[v][7:4]};
            for (int i = 0; i < N; i++) din[i*4 +: 4] = {1'b0, 1'b1, 1'b0, x[i]};
            #1;
            e8[0] = x[0];
            for (int i = 1; i < N; i++) e8[i] = e8[i-1] ^ x[i];
            expect_out("R11 cascade chain", e8, 1'b0, 1'b0);
        end
        cascade_to_in2 = '0;

        // R12: unconnected data inputs read 0
        cfg_all(16'hFFFE, 1'b0, 1'b0);
        din = '1; din_conn = '0; #1;
        expect_out("R12 unconnected data low", 8'h00, 1'b0, 1'b0);
        din_conn = '1; #1;
        expect_out("R12 connected data", 8'hFF, 1'b0, 1'b0);

        // Flip-flop tests: table passes in0; set value = cell bit 0, async = cell bit 1
        cfg_all(16'hAAAA, 1'b0, 1'b1);
        ce = 1'b1; ce_conn = 1'b1; sr = 1'b0; sr_conn = 1'b1;
        @(posedge clk); #1;
        din_in0(8'hA5);
        @(posedge clk); #1;
        expect_out("R5 registered load", 8'hA5, 1'b0, 1'b0);
        din_in0(8'h5A); #1;
        expect_out("R5 no change before edge", 8'hA5, 1'b0, 1'b0);
        @(posedge clk); #1;
        expect_out("R5 load on edge", 8'h5A, 1'b0, 1'b0);

        sr = 1'b1; #0.5;
        expect_out("R8 async acts at once", 8'h9A, 1'b0, 1'b0);
        @(posedge clk); #1;
        expect_out("R7 sync acts on edge", 8'hAA, 1'b0, 1'b0);

        sr = 1'b0; din_in0(8'h0F);
        @(posedge clk); #1;
        expect_out("R5 reload after release", 8'h0F, 1'b0, 1'b0);

        ce = 1'b0; sr = 1'b1; #0.5;
        expect_out("R8 async ignores clock enable", 8'h8B, 1'b0, 1'b0);
        @(posedge clk); #1;
        expect_out("R7 sync needs clock enable", 8'h8B, 1'b0, 1'b0);

        sr = 1'b0; din_in0(8'hF0);
        @(posedge clk); #1;
        expect_out("R9 hold with enable low", 8'h8B, 1'b0, 1'b0);

        ce_conn = 1'b0;
        @(posedge clk); #1;
        expect_out("R12 unconnected enable reads 1", 8'hF0, 1'b0, 1'b0);

        sr_conn = 1'b0; sr = 1'b1; din_in0(8'h3C); #0.5;
        expect_out("R12 unconnected set/reset no async", 8'hF0, 1'b0, 1'b0);
        @(posedge clk); #1;
        expect_out("R12 unconnected set/reset reads 0", 8'h3C, 1'b0, 1'b0);

        // R6: falling-edge operation (switched while clk is high)
        sr = 1'b0; sr_conn = 1'b1;
        @(posedge clk); #1;
        neg_clk = 1'b1; din_in0(8'hC3);
        #2;
        expect_out("R6 load on falling edge", 8'hC3, 1'b0, 1'b0);
        din_in0(8'h99);
        @(posedge clk); #1;
        expect_out("R6 rising edge ignored", 8'hC3, 1'b0, 1'b0);
        @(negedge clk); #1;
        expect_out("R6 next falling edge", 8'h99, 1'b0, 1'b0);

        wait (q_tag.size() == 0);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule